// File: doc/BRIEF.md
# DDR Burst Column Address Sequencer

This block produces the column address of every beat of one DDR SDRAM read or write burst. A single-cycle start pulse loads a starting column, a burst length code and an ordering type. From the next cycle on, the block presents one column address per clock, with a beat strobe, until the burst is done. It flags the final beat and then returns to idle.

Addresses never leave the aligned block that the burst length defines. In sequential order the low offset counts up from the starting offset and wraps around inside that block. In interleaved order the offset for beat k is the starting offset XOR k. The logical column index is mapped onto the device address pins with the A10 position skipped, because that pin has another meaning during column commands. A command scheduler drives the start pulse and uses the busy output to hold off the next burst.

Top module: `ddr_burst_seq`

## Requirements
- R1: The length code `blen_i` selects the beat count: 3'd1 gives 2 beats, 3'd2 gives 4 beats and 3'd3 gives 8 beats. One beat is presented per clock cycle with no gaps.
- R2: When `start_i` is high on a rising edge while the block is idle, the block captures `col_i`, `blen_i` and `btype_i`. The first beat appears with `valid_o` high in the cycle after that edge and carries the starting column unchanged.
- R3: With `btype_i` = 0 (sequential), the beat-k offset is (start offset + k) modulo N, where N is the beat count. For example, N=8 from offset 5 gives 5,6,7,0,1,2,3,4.
- R4: With `btype_i` = 1 (interleaved), the beat-k offset is the start offset XOR k. For example, N=8 from offset 5 gives 5,4,7,6,1,0,3,2, and N=4 from offset 3 gives 3,2,1,0.
- R5: Only the low log2(N) column bits change during a burst. Every column bit above them keeps the value it had in the captured start column.
- R6: Logical column bits 0 to 9 drive `addr_o[9:0]`, and logical bit 10 drives `addr_o[11]`. `addr_o[10]` is always 0.
- R7: `last_o` is high only on the final beat. In the cycle after the final beat, `valid_o`, `busy_o` and `last_o` are all low.
- R8: `busy_o` is high from the first beat through the last beat. A `start_i` pulse seen while busy is ignored: the running burst continues unchanged and no further burst follows it.
- R9: A start pulse seen while idle with any length code other than 1, 2 or 3 starts no burst. It raises `err_o` for exactly the next cycle.
- R10: A synchronous active-low reset clears all outputs to 0 and aborts any running burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Burst start pulse |
| col_i | input | COL_BITS | Starting logical column index |
| blen_i | input | 3 | Burst length code (1=2, 2=4, 3=8 beats) |
| btype_i | input | 1 | Ordering: 0 sequential, 1 interleaved |
| addr_o | output | PHY_W | Column address on device pin positions, A10 held low |
| valid_o | output | 1 | Beat strobe |
| last_o | output | 1 | Final beat of the burst |
| busy_o | output | 1 | Burst in progress |
| err_o | output | 1 | One-cycle pulse for an invalid length code |

## Verification
The bench builds the block with its default settings: eleven logical column bits, which gives a twelve-bit pin bus, and a largest burst of eight beats. With these values the logical bit that lands on A11 is exercised, so the skipped A10 position is visible at the pins. Every length and both orderings are reachable, including eight-beat wraps from each corner of the block. The starting columns carry nonzero upper bits, so any leak of offset arithmetic into the fixed part of the column shows up directly on the address output.

// File: rtl/ddr_bseq_pkg.sv
// Package: shared constants and types for the burst column sequencer.
// Assumes burst length codes are log2 of the beat count.
package ddr_bseq_pkg;
    localparam int CODE_W = 3;

    typedef enum logic {
        ORDER_SEQ = 1'b0,
        ORDER_XOR = 1'b1
    } order_e;
endpackage

// File: rtl/ddr_bseq_decode.sv
// Module: decodes the burst length code into a low-offset mask.
// Assumes a code c is legal for 1 <= c <= OFF_W and then means 2**c beats.
module ddr_bseq_decode
    import ddr_bseq_pkg::*;
#(
    parameter int OFF_W = 3
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [OFF_W-1:0]  mask_o,
    output logic              ok_o
);
    // Mark codes in range as legal and build the matching mask.
    always_comb begin
        ok_o   = (code_i != '0) && (int'(code_i) <= OFF_W);
        mask_o = '0;
        for (int b = 0; b < OFF_W; b++) begin
            if (b < int'(code_i)) mask_o[b] = 1'b1;
        end
        if (!ok_o) mask_o = '0;
    end
endmodule

// File: rtl/ddr_bseq_offset.sv
// Module: computes the in-block offset for one beat.
// Assumes the caller masks the result to the burst length; modulo
// wrap comes from the fixed OFF_W-bit width.
module ddr_bseq_offset
    import ddr_bseq_pkg::*;
#(
    parameter int OFF_W = 3
) (
    input  logic [OFF_W-1:0] start_i,
    input  logic [OFF_W-1:0] beat_i,
    input  order_e           order_i,
    output logic [OFF_W-1:0] off_o
);
    // Select the wrapping count or the XOR ordering.
    always_comb begin
        if (order_i == ORDER_XOR) off_o = start_i ^ beat_i;
        else                      off_o = start_i + beat_i;
    end
endmodule

// File: rtl/ddr_bseq_pinmap.sv
// Module: places the logical column bits onto device address pin positions.
// Assumes pin A10 is not a column bit; logical bits at and above 10 move up by one.
module ddr_bseq_pinmap #(
    parameter int COL_BITS = 11,
    parameter int PHY_W    = 12
) (
    input  logic [COL_BITS-1:0] col_i,
    output logic [PHY_W-1:0]    pin_o
);
    for (genvar p = 0; p < PHY_W; p++) begin : g_pin
        if (p < 10 || PHY_W == COL_BITS) begin : g_low
            assign pin_o[p] = col_i[p];
        end else if (p == 10) begin : g_gap
            assign pin_o[p] = 1'b0;
        end else begin : g_high
            assign pin_o[p] = col_i[p-1];
        end
    end
endmodule

// File: rtl/ddr_burst_seq.sv
// Module: top of the burst column sequencer. Captures a start column,
// a length and an order, then presents one column address per clock.
// Assumes COL_BITS >= OFF_W and that start is a single-cycle request.
module ddr_burst_seq
    import ddr_bseq_pkg::*;
#(
    parameter int COL_BITS  = 11,
    parameter int MAX_BURST = 8,
    localparam int PHY_W    = (COL_BITS > 10) ? COL_BITS + 1 : COL_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [COL_BITS-1:0] col_i,
    input  logic [CODE_W-1:0]   blen_i,
    input  logic                btype_i,
    output logic [PHY_W-1:0]    addr_o,
    output logic                valid_o,
    output logic                last_o,
    output logic                busy_o,
    output logic                err_o
);
    localparam int OFF_W = $clog2(MAX_BURST);

    logic                active_q;
    logic [OFF_W-1:0]    beat_q;
    logic [OFF_W-1:0]    mask_q;
    logic [COL_BITS-1:0] col_q;
    order_e              order_q;
    logic                err_q;

    logic [OFF_W-1:0]    dec_mask;
    logic                dec_ok;
    logic [OFF_W-1:0]    beat_off;
    logic [COL_BITS-1:0] mask_ext;
    logic [COL_BITS-1:0] off_ext;
    logic [COL_BITS-1:0] cur_col;
    logic [PHY_W-1:0]    pin_addr;
    logic                at_end;

    ddr_bseq_decode #(.OFF_W(OFF_W)) u_dec (
        .code_i (blen_i),
        .mask_o (dec_mask),
        .ok_o   (dec_ok)
    );

    ddr_bseq_offset #(.OFF_W(OFF_W)) u_off (
        .start_i (col_q[OFF_W-1:0]),
        .beat_i  (beat_q),
        .order_i (order_q),
        .off_o   (beat_off)
    );

    // Widen the mask and offset to the full column width.
    always_comb begin
        mask_ext = '0;
        off_ext  = '0;
        mask_ext[OFF_W-1:0] = mask_q;
        off_ext[OFF_W-1:0]  = beat_off & mask_q;
        cur_col  = (col_q & ~mask_ext) | off_ext;
        at_end   = active_q && (beat_q == mask_q);
    end

    ddr_bseq_pinmap #(.COL_BITS(COL_BITS), .PHY_W(PHY_W)) u_map (
        .col_i (cur_col),
        .pin_o (pin_addr)
    );

    // Burst state: capture on an idle start, step each beat, stop after the last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            beat_q   <= '0;
            mask_q   <= '0;
            col_q    <= '0;
            order_q  <= ORDER_SEQ;
            err_q    <= 1'b0;
        end else begin
            err_q <= 1'b0;
            if (active_q) begin
                if (at_end) active_q <= 1'b0;
                else        beat_q   <= beat_q + 1'b1;
            end else if (start_i) begin
                if (dec_ok) begin
                    active_q <= 1'b1;
                    beat_q   <= '0;
                    mask_q   <= dec_mask;
                    col_q    <= col_i;
                    order_q  <= order_e'(btype_i);
                end else begin
                    err_q <= 1'b1;
                end
            end
        end
    end

    // Drive the outputs; the address bus is quiet while idle.
    always_comb begin
        addr_o  = active_q ? pin_addr : '0;
        valid_o = active_q;
        busy_o  = active_q;
        last_o  = at_end;
        err_o   = err_q;
    end
endmodule

// File: rtl/ddr_burst_seq_chk.sv
// Module: property checker for the burst sequencer, bound to the top.
// Assumes OFF_W low pin bits carry the in-block offset.
module ddr_burst_seq_chk #(
    parameter int PHY_W = 12,
    parameter int OFF_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [PHY_W-1:0] addr_o,
    input logic             valid_o,
    input logic             last_o,
    input logic             busy_o,
    input logic             err_o
);
    AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o); // R7

    AST_LAST_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |=> (!valid_o && !busy_o)); // R7

    AST_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(valid_o) && !$past(last_o))
        |-> (addr_o[PHY_W-1:OFF_W] == $past(addr_o[PHY_W-1:OFF_W]))); // R5

    AST_OFFSET_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(valid_o) && !$past(last_o))
        |-> (addr_o[OFF_W-1:0] != $past(addr_o[OFF_W-1:0]))); // R3

    AST_ERR_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (!valid_o && !busy_o)); // R9

    AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o); // R9

    if (PHY_W > 10) begin : g_gap
        AST_A10_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            !addr_o[10]); // R6
    end
endmodule

bind ddr_burst_seq ddr_burst_seq_chk #(.PHY_W(PHY_W), .OFF_W(OFF_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr_o  (addr_o),
    .valid_o (valid_o),
    .last_o  (last_o),
    .busy_o  (busy_o),
    .err_o   (err_o)
);

// File: tb/ddr_burst_seq_bench.sv
// Bench: walks a table of bursts, then runs directed reset and corner tests.
module ddr_burst_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [10:0] col_i = '0;
    logic [2:0]  blen_i = '0;
    logic        btype_i = 1'b0;
    logic [11:0] addr_o;
    logic        valid_o, last_o, busy_o, err_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ddr_burst_seq u_ddr_burst_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .col_i(col_i),
        .blen_i(blen_i), .btype_i(btype_i), .addr_o(addr_o),
        .valid_o(valid_o), .last_o(last_o), .busy_o(busy_o), .err_o(err_o)
    );

    typedef struct packed {
        logic [2:0]  code;
        logic        itype;
        logic [10:0] col;
        logic [31:0] seq;   // nibble k = expected offset of beat k
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{3'd3, 1'b0, 11'h7FD, 32'h4321_0765},
        '{3'd3, 1'b1, 11'h405, 32'h2301_6745},
        '{3'd2, 1'b1, 11'h3AB, 32'h0000_0123},
        '{3'd2, 1'b0, 11'h58E, 32'h0000_1032},
        '{3'd1, 1'b0, 11'h2C9, 32'h0000_0001},
        '{3'd1, 1'b1, 11'h400, 32'h0000_0010},
        '{3'd3, 1'b1, 11'h0FF, 32'h0123_4567},
        '{3'd3, 1'b0, 11'h7F8, 32'h7654_3210},
        '{3'd3, 1'b0, 11'h403, 32'h2107_6543}
    };

    function automatic logic [11:0] to_pins(logic [10:0] c);
        return {c[10], 1'b0, c[9:0]};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Run one legal burst and check every beat plus the idle cycle after it.
    task automatic run_burst(vec_t v, int inject_at);
        int n;
        logic [10:0] mask;
        logic [10:0] exp_col;
        n = 1 << v.code;
        mask = 11'(n - 1);
        @(negedge clk);
        start_i = 1'b1; col_i = v.col; blen_i = v.code; btype_i = v.itype;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k < n; k++) begin
            if (k > 0) @(negedge clk);
            start_i = 1'b0;
            exp_col = (v.col & ~mask) | (11'(v.seq[4*k +: 4]) & mask);
            check("R2_R3_R4_R5_R6 addr", 32'(addr_o), 32'(to_pins(exp_col)));
            check("R1 valid", 32'(valid_o), 32'd1);
            check("R8 busy", 32'(busy_o), 32'd1);
            check("R7 last", 32'(last_o), 32'(k == n - 1));
            if (k == inject_at) begin
                start_i = 1'b1; col_i = 11'h000; blen_i = 3'd1; btype_i = 1'b1;
            end
        end
        @(negedge clk);
        start_i = 1'b0;
        check("R7 idle after last", {valid_o, busy_o, last_o}, 3'b000);
        @(negedge clk);
        check("R8 no extra burst", {valid_o, busy_o}, 2'b00);
    endtask

    // Give an illegal code and check for the one-cycle error and no burst.
    task automatic bad_code(logic [2:0] code);
        @(negedge clk);
        start_i = 1'b1; blen_i = code; col_i = 11'h155;
        @(negedge clk);
        start_i = 1'b0;
        check("R9 err pulse", 32'(err_o), 32'd1);
        check("R9 no burst", {valid_o, busy_o}, 2'b00);
        @(negedge clk);
        check("R9 err clears", {err_o, valid_o}, 2'b00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R10 reset outputs", {addr_o, valid_o, last_o, busy_o, err_o}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 idle after reset", {valid_o, busy_o, err_o}, 3'b000);

        for (int i = 0; i < NV; i++) run_burst(VECS[i], -1);

        // R8: start during beat 2 and on the final beat are both ignored
        run_burst(VECS[8], 2);
        run_burst(VECS[0], 7);

        bad_code(3'd0);
        bad_code(3'd4);
        bad_code(3'd7);

        // R10: reset in the middle of a burst aborts it
        @(negedge clk);
        start_i = 1'b1; col_i = 11'h7FD; blen_i = 3'd3; btype_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 abort", {addr_o, valid_o, last_o, busy_o, err_o}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 stays idle", {valid_o, busy_o}, 2'b00);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule